// File: doc/BRIEF.md
# I2C Register-Access Master

This block is a single-master I2C engine that carries out one complete register transaction per command. A host strobes in a command: probe, write, or read. With it come a 7-bit device address, an 8-bit register offset and a write byte. The engine then drives the bus through open-drain style pins, each of which is either pulled low or released. When it finishes it reports a one-cycle done pulse, an error flag and, for reads, the byte returned by the device.

Bit timing comes from one clock-frequency parameter and one bus-rate parameter, which set a quarter-bit period. Each bit is built as a quarter with SCL low, a half with SCL high and a quarter with SCL low. START, repeated START and STOP use the same quarter grid. A static swap input reroutes the internal clock and data functions onto the opposite physical pins. This serves boards where the two bus wires are crossed.

Top module: `i2c_reg_master`

## Requirements
- R1: After reset and after every STOP, both pins are released, with `scl_pin_low_o` = 0 and `sda_pin_low_o` = 0. During reset, `done_o`, `err_o` and `rdata_o` are 0.
- R2: With Q = CLK_HZ/(4*BUS_HZ) clock cycles, every data or acknowledge bit holds SCL high for exactly 2Q cycles. In a START, SDA falls while SCL is high and SCL falls exactly Q cycles later. The SCL high span that ends in a START plus its hold is at least 5Q cycles.
- R3: `cmd_op_i` = 0 (probe; code 3 behaves the same) sends START, the byte {address, 0}, then STOP. `err_o` is 0 only if that byte is acknowledged.
- R4: `cmd_op_i` = 1 (write) sends START, {address, 0}, the register offset, the data byte, then STOP.
- R5: `cmd_op_i` = 2 (read) sends START, {address, 0}, the offset, a repeated START and {address, 1}. It then clocks in 8 bits MSB first and answers them with a non-acknowledge (SDA left high). Last comes STOP, and the byte appears on `rdata_o`.
- R6: A non-acknowledge (SDA high in the ninth clock) after any byte the master sends ends the transaction with STOP at once. No further byte is sent and `err_o` is 1.
- R7: Bytes go out MSB first. Within a transaction SDA changes while SCL is high only for START and STOP.
- R8: With `swap_i` = 1, the internal clock drives and senses the physical data pin, and the internal data drives and senses the physical clock pin.
- R9: A command strobe that arrives while a transaction is in progress is ignored.
- R10: `done_o` is a single-cycle pulse at the end of each accepted command. `err_o` holds its value from that pulse until the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe, taken only when idle |
| cmd_op_i | input | 2 | 0 probe, 1 write, 2 read, 3 probe |
| dev_addr_i | input | 7 | Target device address |
| reg_addr_i | input | 8 | Register offset |
| wdata_i | input | 8 | Byte for a write command |
| swap_i | input | 1 | Static pin swap select |
| rdata_o | output | 8 | Byte returned by the last successful read |
| done_o | output | 1 | End-of-command pulse |
| err_o | output | 1 | Non-acknowledge seen in the last command |
| scl_pin_low_o | output | 1 | Pull the physical clock pin low |
| sda_pin_low_o | output | 1 | Pull the physical data pin low |
| scl_pin_i | input | 1 | Physical clock pin level (asynchronous) |
| sda_pin_i | input | 1 | Physical data pin level (asynchronous) |

## Verification
Several properties are checked on every cycle: both lines are released while idle, done never lasts two cycles, the latched command cannot change mid-transaction, and a non-acknowledge leads straight into STOP. The assertions also check that data stays put while the clock is high inside a bit and that every phase load asks for one to four quarters. Frame content can only be shown by the bench's scenarios. Those scenarios cover the byte order and count for each command, the repeated START before a read and the master's final non-acknowledge. They also cover the measured high and hold times on the bus, decoding with swapped pins, and the dropped strobe during a busy transaction.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

  typedef enum logic [1:0] {OP_PROBE = 2'd0, OP_WRITE = 2'd1, OP_READ = 2'd2, OP_RSVD = 2'd3} op_e;
  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_BIT, PH_STOP} phase_e;
  typedef enum logic [1:0] {K_START, K_WBYTE, K_RBYTE, K_STOP} kind_e;

  // byte source: 0 addr+W, 1 offset, 2 write data, 3 addr+R
  typedef struct packed {
    kind_e      kind;
    logic [1:0] sel;
  } step_t;

  typedef struct packed {
    op_e        op;
    logic [6:0] addr;
    logic [7:0] rg;
    logic [7:0] wd;
  } cmd_t;

  typedef struct packed {
    phase_e     phase;
    logic [1:0] seg;
    logic [3:0] bit_idx;
    logic [2:0] step;
    kind_e      kind;
    logic [7:0] sh;
    logic       scl;
    logic       sda;
    logic       nack;
    logic       err;
    logic [7:0] rdata;
  } ctl_t;

  function automatic step_t plan_step(op_e op, logic [2:0] idx);
    step_t s;
    s = '{kind: K_STOP, sel: 2'd0};
    unique case (op)
      OP_WRITE: unique case (idx)
        3'd0: s.kind = K_START;
        3'd1: s = '{kind: K_WBYTE, sel: 2'd0};
        3'd2: s = '{kind: K_WBYTE, sel: 2'd1};
        3'd3: s = '{kind: K_WBYTE, sel: 2'd2};
        default: s.kind = K_STOP;
      endcase
      OP_READ: unique case (idx)
        3'd0: s.kind = K_START;
        3'd1: s = '{kind: K_WBYTE, sel: 2'd0};
        3'd2: s = '{kind: K_WBYTE, sel: 2'd1};
        3'd3: s.kind = K_START;
        3'd4: s = '{kind: K_WBYTE, sel: 2'd3};
        3'd5: s = '{kind: K_RBYTE, sel: 2'd0};
        default: s.kind = K_STOP;
      endcase
      default: unique case (idx)
        3'd0: s.kind = K_START;
        3'd1: s = '{kind: K_WBYTE, sel: 2'd0};
        default: s.kind = K_STOP;
      endcase
    endcase
    return s;
  endfunction

endpackage

// File: rtl/i2c_qtr_timer.sv
module i2c_qtr_timer #(
  parameter int unsigned QTR_CYC = 312,
  parameter int unsigned MAX_QTR = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [2:0] quarters_i,
  output logic       expire_o
);
  localparam int unsigned SPAN  = MAX_QTR * QTR_CYC;
  localparam int unsigned CNT_W = $clog2(SPAN);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= CNT_W'(32'(quarters_i) * QTR_CYC - 32'd1);
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = (cnt_q == '0);

  initial begin
    if (QTR_CYC < 2) $error("QTR_CYC must be at least 2");
  end

  a_r2_quarter_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (quarters_i >= 3'd1 && 32'(quarters_i) <= MAX_QTR));
  a_r2_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) < SPAN);
endmodule

// File: rtl/i2c_pin_map.sv
module i2c_pin_map #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic swap_i,
  input  logic scl_lvl_i,
  input  logic sda_lvl_i,
  input  logic scl_pin_i,
  input  logic sda_pin_i,
  output logic scl_pin_low_o,
  output logic sda_pin_low_o,
  output logic scl_sense_o,
  output logic sda_sense_o
);
  logic [SYNC_STAGES-1:0] pa_s, pb_s;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin pa_s <= '1; pb_s <= '1; end
        else begin pa_s <= scl_pin_i; pb_s <= sda_pin_i; end
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin pa_s <= '1; pb_s <= '1; end
        else begin
          pa_s <= {pa_s[SYNC_STAGES-2:0], scl_pin_i};
          pb_s <= {pb_s[SYNC_STAGES-2:0], sda_pin_i};
        end
      end
    end
  endgenerate

  // release = 1 means the pin floats high
  assign scl_pin_low_o = swap_i ? !sda_lvl_i : !scl_lvl_i;
  assign sda_pin_low_o = swap_i ? !scl_lvl_i : !sda_lvl_i;
  assign scl_sense_o   = swap_i ? pb_s[SYNC_STAGES-1] : pa_s[SYNC_STAGES-1];
  assign sda_sense_o   = swap_i ? pa_s[SYNC_STAGES-1] : pb_s[SYNC_STAGES-1];
endmodule

// File: rtl/i2c_reg_master.sv
module i2c_reg_master
  import i2c_reg_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned BUS_HZ      = 100_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_op_i,
  input  logic [6:0] dev_addr_i,
  input  logic [7:0] reg_addr_i,
  input  logic [7:0] wdata_i,
  input  logic       swap_i,
  output logic [7:0] rdata_o,
  output logic       done_o,
  output logic       err_o,
  output logic       scl_pin_low_o,
  output logic       sda_pin_low_o,
  input  logic       scl_pin_i,
  input  logic       sda_pin_i
);
  localparam int unsigned QTR_CYC = CLK_HZ / (4 * BUS_HZ);

  localparam ctl_t CTL_RST = '{phase: PH_IDLE, seg: 2'd0, bit_idx: 4'd0, step: 3'd0,
                               kind: K_START, sh: 8'h00, scl: 1'b1, sda: 1'b1,
                               nack: 1'b0, err: 1'b0, rdata: 8'h00};

  ctl_t  c_q, c_d;
  cmd_t  k_q, k_d;
  logic  done_q, done_d;
  logic  tmr_load, tmr_exp;
  logic  [2:0] tmr_qtrs;
  logic  scl_sense, sda_sense;
  step_t nxt_st;
  logic  go_next, go_stop;
  logic  [7:0] sel_byte;

  i2c_qtr_timer #(.QTR_CYC(QTR_CYC), .MAX_QTR(4)) i_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .quarters_i(tmr_qtrs), .expire_o(tmr_exp)
  );

  i2c_pin_map #(.SYNC_STAGES(SYNC_STAGES)) i_pins (
    .clk_i, .rst_ni, .swap_i,
    .scl_lvl_i(c_q.scl), .sda_lvl_i(c_q.sda),
    .scl_pin_i, .sda_pin_i,
    .scl_pin_low_o, .sda_pin_low_o,
    .scl_sense_o(scl_sense), .sda_sense_o(sda_sense)
  );

  always_comb begin
    nxt_st = plan_step(k_q.op, c_q.step + 3'd1);
    unique case (nxt_st.sel)
      2'd0:    sel_byte = {k_q.addr, 1'b0};
      2'd1:    sel_byte = k_q.rg;
      2'd2:    sel_byte = k_q.wd;
      default: sel_byte = {k_q.addr, 1'b1};
    endcase
  end

  always_comb begin
    c_d      = c_q;
    k_d      = k_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_qtrs = 3'd1;
    go_next  = 1'b0;
    go_stop  = 1'b0;

    unique case (c_q.phase)
      PH_IDLE: if (cmd_valid_i) begin
        k_d       = '{op: op_e'(cmd_op_i), addr: dev_addr_i, rg: reg_addr_i, wd: wdata_i};
        c_d.err   = 1'b0;
        c_d.phase = PH_START;
        c_d.kind  = K_START;
        c_d.seg   = 2'd0;
        c_d.step  = 3'd0;
        c_d.scl   = 1'b1;
        c_d.sda   = 1'b1;
        tmr_load  = 1'b1;
        tmr_qtrs  = 3'd4;
      end
      PH_START: if (tmr_exp) begin
        if (c_q.seg == 2'd0) begin
          c_d.seg  = 2'd1;
          c_d.sda  = 1'b0;
          tmr_load = 1'b1;
        end else begin
          go_next = 1'b1;
        end
      end
      PH_BIT: if (tmr_exp) begin
        unique case (c_q.seg)
          2'd0: begin
            c_d.seg  = 2'd1;
            c_d.scl  = 1'b1;
            tmr_load = 1'b1;
            tmr_qtrs = 3'd2;
          end
          2'd1: begin
            c_d.seg  = 2'd2;
            c_d.scl  = 1'b0;
            tmr_load = 1'b1;
            // sense path lags the pin, so this still reflects the high phase
            if (c_q.kind == K_RBYTE && c_q.bit_idx != 4'd8) c_d.sh = {c_q.sh[6:0], sda_sense};
            if (c_q.kind == K_WBYTE && c_q.bit_idx == 4'd8) c_d.nack = sda_sense;
          end
          default: begin
            if (c_q.bit_idx != 4'd8) begin
              c_d.bit_idx = c_q.bit_idx + 4'd1;
              c_d.seg     = 2'd0;
              tmr_load    = 1'b1;
              if (c_q.kind == K_WBYTE) begin
                c_d.sh  = {c_q.sh[6:0], 1'b0};
                c_d.sda = (c_q.bit_idx < 4'd7) ? c_q.sh[6] : 1'b1;
              end else begin
                c_d.sda = 1'b1;
              end
            end else if (c_q.kind == K_WBYTE && c_q.nack) begin
              c_d.err = 1'b1;
              go_stop = 1'b1;
            end else begin
              if (c_q.kind == K_RBYTE) c_d.rdata = c_q.sh;
              go_next = 1'b1;
            end
          end
        endcase
      end
      default: if (tmr_exp) begin
        unique case (c_q.seg)
          2'd0: begin
            c_d.seg  = 2'd1;
            c_d.scl  = 1'b1;
            tmr_load = 1'b1;
            tmr_qtrs = 3'd2;
          end
          2'd1: begin
            c_d.seg  = 2'd2;
            c_d.sda  = 1'b1;
            tmr_load = 1'b1;
          end
          default: begin
            c_d.phase = PH_IDLE;
            c_d.seg   = 2'd0;
            done_d    = 1'b1;
          end
        endcase
      end
    endcase

    if (go_stop || (go_next && nxt_st.kind == K_STOP)) begin
      if (go_next) c_d.step = c_q.step + 3'd1;
      c_d.phase = PH_STOP;
      c_d.kind  = K_STOP;
      c_d.seg   = 2'd0;
      c_d.scl   = 1'b0;
      c_d.sda   = 1'b0;
      tmr_load  = 1'b1;
      tmr_qtrs  = 3'd1;
    end else if (go_next) begin
      c_d.step    = c_q.step + 3'd1;
      c_d.kind    = nxt_st.kind;
      c_d.seg     = 2'd0;
      c_d.bit_idx = 4'd0;
      tmr_load    = 1'b1;
      if (nxt_st.kind == K_START) begin
        c_d.phase = PH_START;
        c_d.scl   = 1'b1;
        c_d.sda   = 1'b1;
        tmr_qtrs  = 3'd4;
      end else begin
        c_d.phase = PH_BIT;
        c_d.scl   = 1'b0;
        c_d.sh    = sel_byte;
        c_d.sda   = (nxt_st.kind == K_WBYTE) ? sel_byte[7] : 1'b1;
        tmr_qtrs  = 3'd1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_q    <= CTL_RST;
      k_q    <= '{op: OP_PROBE, addr: 7'd0, rg: 8'd0, wd: 8'd0};
      done_q <= 1'b0;
    end else begin
      c_q    <= c_d;
      k_q    <= k_d;
      done_q <= done_d;
    end
  end

  assign rdata_o = c_q.rdata;
  assign done_o  = done_q;
  assign err_o   = c_q.err;

  a_r1_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_q.phase == PH_IDLE) |-> (!scl_pin_low_o && !sda_pin_low_o));
  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_cmd_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_q.phase != PH_IDLE) |=> ($stable(k_q.op) && $stable(k_q.addr) && $stable(k_q.rg)));
  a_r6_nack_to_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> (c_q.phase == PH_STOP && c_q.seg == 2'd0));
  a_r7_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_q.phase == PH_BIT && $past(c_q.phase == PH_BIT) && c_q.scl && $past(c_q.scl))
      |-> $stable(c_q.sda));
endmodule

// File: tb/test_i2c_reg_master.sv
module test_i2c_reg_master;
  localparam int unsigned Q   = 10;
  localparam logic [6:0]  SLV = 7'h2A;
  localparam int          WD_CYC = 150000;

  typedef struct packed {
    logic [1:0] op;
    logic [6:0] addr;
    logic [7:0] rg;
    logic [7:0] wd;
    logic       sw;
    logic [2:0] nack_at;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 7'h2A, 8'h00, 8'h00, 1'b0, 3'd7},
    '{2'd0, 7'h11, 8'h00, 8'h00, 1'b0, 3'd7},
    '{2'd1, 7'h2A, 8'h10, 8'hA5, 1'b0, 3'd7},
    '{2'd1, 7'h2A, 8'h80, 8'h01, 1'b0, 3'd1},
    '{2'd1, 7'h2A, 8'h33, 8'hCC, 1'b0, 3'd2},
    '{2'd2, 7'h2A, 8'h3C, 8'h00, 1'b0, 3'd7},
    '{2'd2, 7'h2A, 8'h00, 8'h00, 1'b0, 3'd7},
    '{2'd2, 7'h2A, 8'h44, 8'h00, 1'b0, 3'd1},
    '{2'd2, 7'h2A, 8'h55, 8'h00, 1'b0, 3'd2},
    '{2'd1, 7'h2A, 8'h5A, 8'h96, 1'b1, 3'd7},
    '{2'd2, 7'h2A, 8'h7E, 8'h00, 1'b1, 3'd7},
    '{2'd0, 7'h00, 8'h00, 8'h00, 1'b1, 3'd7},
    '{2'd3, 7'h2A, 8'h00, 8'h00, 1'b0, 3'd7}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, swap = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [6:0] dev_addr = 7'd0;
  logic [7:0] reg_addr = 8'd0, wdata = 8'd0;
  logic [7:0] rdata;
  logic done, err, scl_low, sda_low;
  logic slv_pull = 1'b0;
  logic phys_scl, phys_sda, dev_scl, dev_sda;
  logic mon_clr = 1'b0;
  logic [2:0] nack_at = 3'd7;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign phys_scl = !(scl_low || (swap && slv_pull));
  assign phys_sda = !(sda_low || (!swap && slv_pull));
  assign dev_scl  = swap ? phys_sda : phys_scl;
  assign dev_sda  = swap ? phys_scl : phys_sda;

  i2c_reg_master #(.CLK_HZ(4_000_000), .BUS_HZ(100_000)) i_i2c_reg_master (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .dev_addr_i(dev_addr), .reg_addr_i(reg_addr), .wdata_i(wdata), .swap_i(swap),
    .rdata_o(rdata), .done_o(done), .err_o(err),
    .scl_pin_low_o(scl_low), .sda_pin_low_o(sda_low),
    .scl_pin_i(phys_scl), .sda_pin_i(phys_sda)
  );

  // bus monitor and device model
  logic [7:0] log_b [8];
  int n_log = 0, n_start = 0, n_stop = 0, bad_high = 0, hold_bad = 0, sda_hi_edges = 0;
  int hi_len = 0, hold_cnt = 0, bitn = 0, bif = 0;
  bit hold_on = 0, tx = 0, tx_pend = 0, prev_scl = 1, prev_sda = 1;
  logic m_nack = 1'b0;
  logic [7:0] sh = 8'h00;

  always @(posedge clk) begin
    logic cs, cd, ack;
    logic [7:0] rb;
    cs = dev_scl;
    cd = dev_sda;
    if (mon_clr) begin
      n_log = 0; n_start = 0; n_stop = 0; bad_high = 0; hold_bad = 0; sda_hi_edges = 0;
      hi_len = 0; hold_on = 0; bitn = 0; bif = 0; tx = 0; tx_pend = 0; slv_pull = 1'b0;
      m_nack = 1'b0;
    end else begin
      if (prev_scl && cs && (prev_sda != cd)) begin
        sda_hi_edges++;
        if (!cd) begin
          n_start++; bitn = 0; bif = 0; tx = 0; tx_pend = 0; slv_pull = 1'b0;
          hold_on = 1; hold_cnt = 0;
        end else begin
          n_stop++; slv_pull = 1'b0;
        end
      end
      if (cs) hi_len++;
      if (!prev_scl && cs) begin
        if (!tx) begin
          if (bitn < 8) sh = {sh[6:0], cd};
        end else if (bitn == 8) m_nack = cd;
        if (bitn < 9) bitn++;
      end
      if (prev_scl && !cs) begin
        if (hi_len != 2 * Q && hi_len < 5 * Q) bad_high++;
        hi_len = 0;
        if (hold_on) begin
          if (hold_cnt != Q) hold_bad++;
          hold_on = 0;
        end
        rb = log_b[1] ^ 8'hC3;
        if (bitn == 8) begin
          if (!tx) begin
            ack = 1'b1;
            if (bif == 0 && sh[7:1] != SLV) ack = 1'b0;
            if (n_log == int'(nack_at)) ack = 1'b0;
            if (bif == 0 && sh[0] && ack) tx_pend = 1;
            if (n_log < 8) log_b[n_log] = sh;
            n_log++;
            bif++;
            slv_pull = ack;
          end else slv_pull = 1'b0;
        end else if (bitn == 9) begin
          bitn = 0;
          slv_pull = 1'b0;
          tx = 0;
          if (tx_pend) begin
            tx = 1; tx_pend = 0; slv_pull = !rb[7];
          end
        end else if (tx && bitn >= 1 && bitn <= 7) begin
          slv_pull = !rb[7 - bitn];
        end
      end
      if (hold_on) hold_cnt++;
    end
    prev_scl = cs;
    prev_sda = cd;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_done(output int t);
    t = 0;
    while (!done && t < 6000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic issue(input vec_t v);
    swap = v.sw; nack_at = v.nack_at;
    mon_clr = 1'b1;
    @(negedge clk);
    mon_clr = 1'b0;
    cmd_op = v.op; dev_addr = v.addr; reg_addr = v.rg; wdata = v.wd;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    int t, eff, len, exp_log, exp_starts;
    logic exp_err, e_at_done;
    logic [7:0] eb [3];
    string tg;
    issue(v);
    wait_done(t);
    chk("R10 done pulse seen", 32'(t < 6000), 32'd1);
    e_at_done = err;
    chk("R1 lines released at end", {30'd0, dev_scl & dev_sda, !scl_low & !sda_low}, 32'd3);
    @(negedge clk);
    chk("R10 done lasts one cycle", 32'(done), 32'd0);

    len  = (v.op == 2'd1 || v.op == 2'd2) ? 3 : 1;
    eff  = (v.addr != SLV) ? 0 : int'(v.nack_at);
    exp_err = (eff < len);
    exp_log = exp_err ? eff + 1 : len;
    exp_starts = (v.op == 2'd2 && eff >= 2) ? 2 : 1;
    eb[0] = {v.addr, 1'b0};
    eb[1] = v.rg;
    eb[2] = (v.op == 2'd1) ? v.wd : {v.addr, 1'b1};
    tg = (v.op == 2'd2) ? "R5" : (v.op == 2'd1) ? "R4" : "R3";
    if (exp_err) tg = {tg, " R6"};
    if (v.sw) tg = {tg, " R8"};

    chk({tg, " error flag"}, 32'(e_at_done), 32'(exp_err));
    chk({tg, " byte count"}, 32'(n_log), 32'(exp_log));
    for (int i = 0; i < exp_log && i < 3; i++)
      chk({tg, " R7 byte value"}, 32'(log_b[i]), 32'(eb[i]));
    chk({tg, " start count"}, 32'(n_start), 32'(exp_starts));
    chk({tg, " stop count"}, 32'(n_stop), 32'd1);
    chk("R2 clock high spans", 32'(bad_high), 32'd0);
    chk("R2 start hold", 32'(hold_bad), 32'd0);
    chk("R7 data edges under high clock", 32'(sda_hi_edges), 32'(n_start + n_stop));
    if (v.op == 2'd2 && !exp_err) begin
      chk("R5 read data", 32'(rdata), 32'(v.rg ^ 8'hC3));
      chk("R5 master nack", 32'(m_nack), 32'd1);
    end
    repeat (20) @(negedge clk);
    chk("R10 error held after done", 32'(err), 32'(exp_err));
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int t;
    repeat (3) @(negedge clk);
    chk("R1 reset pins released", {30'd0, scl_low, sda_low}, 32'd0);
    chk("R1 reset outputs", {22'd0, done, err, rdata}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R9: strobe during a busy write is dropped
    issue('{2'd1, SLV, 8'h21, 8'h7F, 1'b0, 3'd7});
    repeat (200) @(negedge clk);
    cmd_op = 2'd2; dev_addr = 7'h11; reg_addr = 8'hEE;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done(t);
    chk("R9 first command completes", 32'(t < 6000), 32'd1);
    chk("R9 no error from ignored strobe", 32'(err), 32'd0);
    chk("R9 frame bytes", 32'(n_log), 32'd3);
    chk("R9 address kept", 32'(log_b[0]), 32'({SLV, 1'b0}));
    chk("R9 offset kept", 32'(log_b[1]), 32'h21);
    repeat (2000) @(negedge clk);
    chk("R9 no second transaction", 32'(n_start), 32'd1);
    chk("R1 idle lines after run", {30'd0, scl_low, sda_low}, 32'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule